// File: doc/BRIEF.md
# Aperture page remapping table

This block remaps a fixed window of bus addresses (the aperture) onto scattered physical pages of 4 KiB. Each page of the window has one entry in an on-chip table. The entry holds a valid flag and a physical frame number. A translation port takes one address per cycle. One cycle later it returns either the remapped address or a fault. Addresses outside the window pass through unchanged.

Software fills the table through three word registers with indirect access. It first writes an aperture address into a selector register. A write to the data register then stores the entry for that page, and a read of the data register returns it. A third register holds a global enable bit. While that bit is clear, every access inside the aperture faults. Reads of the enable register can serve as a completion barrier: they always reflect every earlier register write.

Top module: `aperture_remap`

## Requirements
- R1: After reset, translation is disabled, every entry is invalid, and the selector holds zero. Register reads of the enable, selector and data registers all return 0.
- R2: Every translation request produces exactly one result. It is flagged by `xlValid` one cycle after `xlReq`, and back-to-back requests are accepted every cycle.
- R3: A request whose address lies below `APER_BASE` or at or above `APER_BASE + ENTRIES*4096` returns the same address with `xlFault` low.
- R4: When the block is enabled, a request inside the aperture whose entry is valid returns bit 31 = 0, bits 30:12 = the entry's frame and bits 11:0 = the request's bits 11:0, with no fault. The entry index is (address − `APER_BASE`) >> 12.
- R5: A request inside the aperture whose entry has its valid bit clear raises `xlFault`.
- R6: When the enable bit is 0, every request inside the aperture raises `xlFault`, including requests to valid entries. The bit takes effect for requests from the cycle after the write.
- R7: Register offsets: 0x0 is the enable register (bit 0; the other bits read 0). 0x4 is the selector register, which reads back the full 32-bit value written. 0x8 is the entry data register.
- R8: A write to offset 0x8 stores bit 31 as the valid flag and bits 30:12 as the frame, into the entry selected by the selector. A read of 0x8 returns those bits in the same positions, with bits 11:0 reading as 0.
- R9: When the selector holds an address outside the aperture, writes to 0x8 change no entry and reads of 0x8 return 0.
- R10: Writing 0 to the data register unmaps the selected page. Its entry then reads 0, and translations to it fault.
- R11: Each register read returns its data with `regRdValid` one cycle after `regRdEn`. A read of the enable register issued in the cycle after a write already reflects that write.
- R12: Writes to any other offset are ignored, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 4 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data |
| regRdValid | output | 1 | Read data valid, one cycle after regRdEn |
| xlReq | input | 1 | Translation request |
| xlAddr | input | 32 | Address to translate |
| xlValid | output | 1 | Translation result valid |
| xlPhys | output | 32 | Translated or forwarded address |
| xlFault | output | 1 | Invalid access inside the aperture |

## Verification
Both a translation result and a register read answer exactly one cycle after the request. A register write affects any request or read issued in the next cycle.

Each driver task stamps the expected item with its due cycle, taken as the current cycle count plus one. The monitor samples on the falling edge and compares the stamp against the cycle in which the result actually appears. An early, late, missing or unrequested result therefore fails the latency check, as well as any data check.

// File: rtl/aperture_remap_pkg.sv
package aperture_remap_pkg;
  localparam int DATA_W     = 32;
  localparam int PAGE_SHIFT = 12;
  localparam int FRAME_W    = DATA_W - 1 - PAGE_SHIFT;
  localparam int REG_AW     = 4;

  localparam logic [REG_AW-1:0] OFF_ENABLE = 4'h0;
  localparam logic [REG_AW-1:0] OFF_SELECT = 4'h4;
  localparam logic [REG_AW-1:0] OFF_ENTRY  = 4'h8;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_ENABLE,
    SRC_SELECT,
    SRC_ENTRY
  } rdSrc_e;

  typedef struct packed {
    logic   wrEnable;
    logic   wrSelect;
    logic   wrEntry;
    logic   rdFire;
    rdSrc_e rdSrc;
  } regStrobe_t;

  typedef struct packed {
    logic               valid;
    logic [FRAME_W-1:0] frame;
  } pageEntry_t;
endpackage

// File: rtl/aperture_remap_ctrl.sv
module aperture_remap_ctrl
  import aperture_remap_pkg::*;
(
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [REG_AW-1:0] regAddr,
  output regStrobe_t        strobe
);
  always_comb begin
    strobe          = '0;
    strobe.rdSrc    = SRC_NONE;
    strobe.rdFire   = regRdEn;
    strobe.wrEnable = regWrEn && (regAddr == OFF_ENABLE);
    strobe.wrSelect = regWrEn && (regAddr == OFF_SELECT);
    strobe.wrEntry  = regWrEn && (regAddr == OFF_ENTRY);
    if (regRdEn) begin
      unique case (regAddr)
        OFF_ENABLE: strobe.rdSrc = SRC_ENABLE;
        OFF_SELECT: strobe.rdSrc = SRC_SELECT;
        OFF_ENTRY:  strobe.rdSrc = SRC_ENTRY;
        default:    strobe.rdSrc = SRC_NONE;
      endcase
    end
  end
endmodule

// File: rtl/aperture_remap_dp.sv
module aperture_remap_dp
  import aperture_remap_pkg::*;
#(
  parameter int                ENTRIES   = 256,
  parameter logic [DATA_W-1:0] APER_BASE = 32'h4800_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              regRdValid,
  input  logic              xlReq,
  input  logic [DATA_W-1:0] xlAddr,
  output logic              xlValid,
  output logic [DATA_W-1:0] xlPhys,
  output logic              xlFault
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [DATA_W:0] APER_END =
    {1'b0, APER_BASE} + ((DATA_W+1)'(ENTRIES) << PAGE_SHIFT);

  function automatic logic inWindow(input logic [DATA_W-1:0] a);
    return ({1'b0, a} >= {1'b0, APER_BASE}) && ({1'b0, a} < APER_END);
  endfunction

  function automatic logic [IDX_W-1:0] pageIndex(input logic [DATA_W-1:0] a);
    return IDX_W'((a - APER_BASE) >> PAGE_SHIFT);
  endfunction

  logic              enable;
  logic [DATA_W-1:0] selAddr;
  pageEntry_t        pageTab [ENTRIES];

  logic              selHit;
  logic [IDX_W-1:0]  selIdx;
  pageEntry_t        selEntry;

  assign selHit   = inWindow(selAddr);
  assign selIdx   = pageIndex(selAddr);
  assign selEntry = pageTab[selIdx];

  // Control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable  <= 1'b0;
      selAddr <= '0;
    end else begin
      if (strobe.wrEnable) enable  <= regWrData[0];
      if (strobe.wrSelect) selAddr <= regWrData;
    end
  end

  // Page table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) pageTab[i] <= '0;
    end else if (strobe.wrEntry && selHit) begin
      pageTab[selIdx] <= '{valid: regWrData[DATA_W-1],
                           frame: regWrData[DATA_W-2:PAGE_SHIFT]};
    end
  end

  // Register read path
  logic [DATA_W-1:0] rdNext;
  always_comb begin
    unique case (strobe.rdSrc)
      SRC_ENABLE: rdNext = {{(DATA_W-1){1'b0}}, enable};
      SRC_SELECT: rdNext = selAddr;
      SRC_ENTRY:  rdNext = selHit ? {selEntry.valid, selEntry.frame, {PAGE_SHIFT{1'b0}}}
                                  : '0;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regRdData  <= '0;
      regRdValid <= 1'b0;
    end else begin
      regRdValid <= strobe.rdFire;
      if (strobe.rdFire) regRdData <= rdNext;
    end
  end

  // Translation path
  pageEntry_t        xlEntry;
  logic              xlHit;
  logic [DATA_W-1:0] physNext;
  logic              faultNext;

  assign xlHit   = inWindow(xlAddr);
  assign xlEntry = pageTab[pageIndex(xlAddr)];

  always_comb begin
    physNext  = xlAddr;
    faultNext = 1'b0;
    if (xlHit) begin
      if (enable && xlEntry.valid) begin
        physNext = {1'b0, xlEntry.frame, xlAddr[PAGE_SHIFT-1:0]};
      end else begin
        physNext  = '0;
        faultNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xlValid <= 1'b0;
      xlPhys  <= '0;
      xlFault <= 1'b0;
    end else begin
      xlValid <= xlReq;
      if (xlReq) begin
        xlPhys  <= physNext;
        xlFault <= faultNext;
      end
    end
  end
endmodule

// File: rtl/aperture_remap.sv
module aperture_remap
  import aperture_remap_pkg::*;
#(
  parameter int          ENTRIES   = 256,
  parameter logic [31:0] APER_BASE = 32'h4800_0000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [3:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        regRdValid,
  input  logic        xlReq,
  input  logic [31:0] xlAddr,
  output logic        xlValid,
  output logic [31:0] xlPhys,
  output logic        xlFault
);
  regStrobe_t strobe;

  aperture_remap_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regRdEn (regRdEn),
    .regAddr (regAddr),
    .strobe  (strobe)
  );

  aperture_remap_dp #(
    .ENTRIES   (ENTRIES),
    .APER_BASE (APER_BASE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .regRdValid (regRdValid),
    .xlReq      (xlReq),
    .xlAddr     (xlAddr),
    .xlValid    (xlValid),
    .xlPhys     (xlPhys),
    .xlFault    (xlFault)
  );
endmodule

// File: rtl/aperture_remap_chk.sv
module aperture_remap_chk #(
  parameter int          ENTRIES   = 256,
  parameter logic [31:0] APER_BASE = 32'h4800_0000
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic        regRdEn,
  input logic [3:0]  regAddr,
  input logic [31:0] regWrData,
  input logic        regRdValid,
  input logic        xlReq,
  input logic [31:0] xlAddr,
  input logic        xlValid,
  input logic [31:0] xlPhys,
  input logic        xlFault
);
  function automatic logic insideAp(input logic [31:0] a);
    return (a >= APER_BASE) && (((a - APER_BASE) >> 12) < 32'(ENTRIES));
  endfunction

  assert_xl_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    xlValid == $past(xlReq));

  assert_rd_latency_R11: assert property (@(posedge clk) disable iff (!rstN)
    regRdValid == $past(regRdEn));

  assert_bypass_R3: assert property (@(posedge clk) disable iff (!rstN)
    (xlReq && !insideAp(xlAddr)) |=> (xlValid && !xlFault && xlPhys == $past(xlAddr)));

  assert_offset_R4: assert property (@(posedge clk) disable iff (!rstN)
    (xlReq && insideAp(xlAddr)) |=>
      (xlFault || (xlPhys[11:0] == $past(xlAddr[11:0]) && !xlPhys[31])));

  assert_disabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 4'h0 && !regWrData[0]) ##1 (xlReq && insideAp(xlAddr))
      |=> xlFault);

  assert_fault_scope_R5: assert property (@(posedge clk) disable iff (!rstN)
    (xlReq && !insideAp(xlAddr)) |=> !xlFault);
endmodule

bind aperture_remap aperture_remap_chk #(
  .ENTRIES   (ENTRIES),
  .APER_BASE (APER_BASE)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .regWrEn    (regWrEn),
  .regRdEn    (regRdEn),
  .regAddr    (regAddr),
  .regWrData  (regWrData),
  .regRdValid (regRdValid),
  .xlReq      (xlReq),
  .xlAddr     (xlAddr),
  .xlValid    (xlValid),
  .xlPhys     (xlPhys),
  .xlFault    (xlFault)
);

// File: tb/sim_aperture_remap.sv
module sim_aperture_remap;
  localparam int          ENTRIES = 256;
  localparam logic [31:0] BASE    = 32'h4800_0000;

  logic        clk, rstN;
  logic        regWrEn, regRdEn;
  logic [3:0]  regAddr;
  logic [31:0] regWrData, regRdData;
  logic        regRdValid;
  logic        xlReq;
  logic [31:0] xlAddr, xlPhys;
  logic        xlValid, xlFault;

  aperture_remap #(.ENTRIES(ENTRIES), .APER_BASE(BASE)) u0 (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .regRdValid(regRdValid),
    .xlReq(xlReq), .xlAddr(xlAddr),
    .xlValid(xlValid), .xlPhys(xlPhys), .xlFault(xlFault)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int cycle = 0;
  always @(posedge clk) cycle <= cycle + 1;

  typedef struct {
    int          due;
    logic [31:0] val;
    logic        fault;
    logic        chkVal;
    string       tag;
  } expItem_t;

  expItem_t xlQ[$];
  expItem_t rdQ[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic note(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Monitor: compares results against the scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (xlValid) begin
        if (xlQ.size() == 0) begin
          note(0, "R2", "unrequested translation", 32'd1, 32'd0);
        end else begin
          expItem_t e;
          e = xlQ.pop_front();
          note(cycle == e.due, "R2", {e.tag, " translation cycle"}, cycle, e.due);
          note(xlFault == e.fault, e.tag, "fault flag", {31'b0, xlFault}, {31'b0, e.fault});
          if (e.chkVal) note(xlPhys == e.val, e.tag, "translated address", xlPhys, e.val);
        end
      end
      if (regRdValid) begin
        if (rdQ.size() == 0) begin
          note(0, "R11", "unrequested read data", 32'd1, 32'd0);
        end else begin
          expItem_t e;
          e = rdQ.pop_front();
          note(cycle == e.due, "R11", {e.tag, " read cycle"}, cycle, e.due);
          note(regRdData == e.val, e.tag, "read data", regRdData, e.val);
        end
      end
    end
  end

  // Driver tasks: start and end on a falling edge
  task automatic xlate(input logic [31:0] addr, input logic [31:0] exp,
                       input logic fault, input string tag);
    xlQ.push_back('{due: cycle + 1, val: exp, fault: fault, chkVal: !fault, tag: tag});
    xlReq  = 1'b1;
    xlAddr = addr;
    @(negedge clk);
    xlReq  = 1'b0;
  endtask

  task automatic regWr(input logic [3:0] off, input logic [31:0] data);
    regWrEn   = 1'b1;
    regAddr   = off;
    regWrData = data;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  task automatic regRd(input logic [3:0] off, input logic [31:0] exp, input string tag);
    rdQ.push_back('{due: cycle + 1, val: exp, fault: 1'b0, chkVal: 1'b1, tag: tag});
    regRdEn = 1'b1;
    regAddr = off;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    rstN = 1'b0; regWrEn = 0; regRdEn = 0; regAddr = '0; regWrData = '0;
    xlReq = 0; xlAddr = '0;
    repeat (3) @(negedge clk);
    note(!xlValid && !regRdValid, "R1", "outputs idle in reset",
         {30'b0, xlValid, regRdValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRd(4'h0, 32'h0, "R1");
    regRd(4'h4, 32'h0, "R1");
    regRd(4'h8, 32'h0, "R1");
    xlate(BASE + 32'h10, 32'h0, 1'b1, "R1");
    // R3 bypass outside aperture
    xlate(32'h1000_0123, 32'h1000_0123, 1'b0, "R3");

    // R7 / R8 programming
    regWr(4'h0, 32'h1);
    regRd(4'h0, 32'h1, "R7");
    regWr(4'h4, BASE + 32'h5000);
    regRd(4'h4, BASE + 32'h5000, "R7");
    regWr(4'h8, 32'h8001_20AB);
    regRd(4'h8, 32'h8001_2000, "R8");

    // R4 / R5 translation, back to back (R2)
    xlate(BASE + 32'h5ABC, 32'h0001_2ABC, 1'b0, "R4");
    xlate(BASE + 32'h3004, 32'h0, 1'b1, "R5");
    xlate(BASE + 32'h5000, 32'h0001_2000, 1'b0, "R4");

    // Last entry and aperture edges
    regWr(4'h4, BASE + 32'hFF000);
    regWr(4'h8, 32'hFFFF_F000);
    xlate(BASE + 32'hFF123, 32'h7FFF_F123, 1'b0, "R4");
    xlate(BASE + 32'h100000, BASE + 32'h100000, 1'b0, "R3");
    xlate(BASE - 32'h1, BASE - 32'h1, 1'b0, "R3");

    // R9 selector outside aperture
    regWr(4'h4, 32'h2000_0000);
    regWr(4'h8, 32'h8000_5000);
    regRd(4'h8, 32'h0, "R9");
    regWr(4'h4, BASE);
    regRd(4'h8, 32'h0, "R9");
    xlate(BASE + 32'h0040, 32'h0, 1'b1, "R9");
    regWr(4'h4, BASE + 32'h5000);
    regRd(4'h8, 32'h8001_2000, "R9");

    // R6 global disable, R11 barrier read right after write
    regWr(4'h0, 32'h0);
    regRd(4'h0, 32'h0, "R11");
    xlate(BASE + 32'h5ABC, 32'h0, 1'b1, "R6");
    xlate(BASE + 32'hFF001, 32'h0, 1'b1, "R6");
    xlate(32'h0000_0777, 32'h0000_0777, 1'b0, "R6");
    regWr(4'h0, 32'h1);
    xlate(BASE + 32'h5001, 32'h0001_2001, 1'b0, "R6");

    // R10 unmap
    regWr(4'h8, 32'h0);
    regRd(4'h8, 32'h0, "R10");
    xlate(BASE + 32'h5001, 32'h0, 1'b1, "R10");
    xlate(BASE + 32'hFF001, 32'h7FFF_F001, 1'b0, "R10");

    // R12 unmapped offset
    regWr(4'hC, 32'hFFFF_FFFF);
    regRd(4'hC, 32'h0, "R12");
    regRd(4'h0, 32'h1, "R12");
    regRd(4'h4, BASE + 32'h5000, "R12");

    repeat (3) @(negedge clk);
    note(xlQ.size() == 0 && rdQ.size() == 0, "R2", "results outstanding",
         xlQ.size() + rdQ.size(), 32'd0);
    finishRun();
  end
endmodule